// File: doc/BRIEF.md
# Indirect PCI Configuration and I/O Port Access Bridge

This block gives a host register bus a way to reach PCI configuration space and PCI I/O port space without a direct mapping. Software first loads a shared address register with either a packed configuration address (bus, device/function, dword register offset) or a 16-bit I/O port number. It then reads or writes one of two data windows. The window it touches picks the cycle type: the configuration window issues a configuration cycle and the I/O window issues an I/O cycle.

Each window access becomes exactly one request on a simple downstream request/acknowledge interface. The byte enables for that request come from the host access size and the low offset bits inside the window. The host is held off (ready low) until the downstream side acknowledges. Read data comes back on the selected byte lanes only.

Top module: `pcicfg_port`

## Requirements
- R1: The address register sits at offset 0x064, resets to zero and reads back the last value written. A write updates only the byte lanes enabled by the access size and lane (same rule as R5).
- R2: A read of the configuration window (0x068 to 0x06B) issues one downstream cycle with dn_cfg=1 and dn_we=0. Its dn_addr is address-register bits 23:2 in place, with bits 1:0 and 31:24 zero (bus in 23:16, device/function in 15:8, dword offset in 7:2).
- R3: A write of the configuration window issues one downstream cycle with dn_cfg=1 and dn_we=1 at the R2 address, and carries the host write data on the enabled lanes.
- R4: An access to the I/O window (0x06C to 0x06F) issues a cycle with dn_cfg=0. Its dn_addr is port bits 15:2 in place, with all other bits zero, and dn_we follows the host direction.
- R5: Byte enables: size 0 (byte) gives 1 shifted left by offset bits 1:0. Size 1 (halfword) gives 0011 when offset bit 1 is 0 and 1100 when it is 1. Sizes 2 and 3 give 1111.
- R6: During a window access host_ready stays low until the downstream acknowledge, then is high for exactly the following cycle. dn_req, dn_addr and dn_be hold steady while unacknowledged.
- R7: Read data returns on the enabled lanes; the other lanes read zero. Write accesses return zero.
- R8: An access to any other offset completes in the same cycle, returns zero, starts no downstream cycle and leaves the address register unchanged.
- R9: Each window access produces exactly one downstream cycle, and dn_req is low outside window accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW | Byte offset of the access |
| host_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| host_wdata | input | 32 | Write data, lane-aligned |
| host_ready | output | 1 | Access complete this cycle |
| host_rdata | output | 32 | Read data, valid with host_ready |
| dn_req | output | 1 | Downstream cycle request |
| dn_cfg | output | 1 | 1 = configuration cycle, 0 = I/O cycle |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | DN_AW | Downstream dword address |
| dn_be | output | 4 | Downstream byte enables |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
The bench drives byte accesses at all four lanes, halfword accesses at both halves, and word accesses of size 2 and 3. It runs these against two configuration addresses and one I/O port, with responder latencies from zero to three cycles. Read-after-write across mixed sizes separates wrong lane steering from wrong byte enables, because a responder word that is fully populated exposes any lane the bridge fails to zero. Accesses to an unmapped offset between address-register readbacks show that stray writes touch nothing. A per-clock check of dn_req shows that no extra downstream cycle occurs.

// File: rtl/pcicfg_port_pkg.sv
package pcicfg_port_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_ADDR = 2'd1,
      TGT_CFG  = 2'd2,
      TGT_IO   = 2'd3
   } target_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_DONE = 2'd2
   } seq_state_e;

   // lane enables from access size and the low offset bits
   function automatic logic [3:0] lane_enables(acc_size_e sz, logic [1:0] ofs);
      logic [3:0] r;
      case (sz)
         SZ_BYTE: r = 4'b0001 << ofs;
         SZ_HALF: r = ofs[1] ? 4'b1100 : 4'b0011;
         default: r = 4'b1111;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pcicfg_decode.sv
module pcicfg_decode
   import pcicfg_port_pkg::*;
#(
   parameter int          HOST_AW  = 12,
   parameter int          DATA_W   = 32,
   parameter logic [11:0] ADDR_OFS = 12'h064,
   parameter logic [11:0] CFG_OFS  = 12'h068,
   parameter logic [11:0] IO_OFS   = 12'h06C,
   parameter int          BE_W     = DATA_W / 8
)(
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [1:0]         host_size,
   output target_e            tgt,
   output logic [BE_W-1:0]    be,
   output logic [DATA_W-1:0]  lane_mask
);

   localparam int WORD_AW = HOST_AW - 2;

   logic [WORD_AW-1:0] word_idx;
   assign word_idx = host_addr[HOST_AW-1:2];

   always_comb begin
      if (word_idx == ADDR_OFS[HOST_AW-1:2])
         tgt = TGT_ADDR;
      else if (word_idx == CFG_OFS[HOST_AW-1:2])
         tgt = TGT_CFG;
      else if (word_idx == IO_OFS[HOST_AW-1:2])
         tgt = TGT_IO;
      else
         tgt = TGT_NONE;
   end

   assign be = lane_enables(acc_size_e'(host_size), host_addr[1:0]);

   for (genvar i = 0; i < BE_W; i++) begin : g_lane
      assign lane_mask[8*i +: 8] = {8{be[i]}};
   end

endmodule

// File: rtl/pcicfg_addr_reg.sv
module pcicfg_addr_reg #(
   parameter int DATA_W = 32,
   parameter int BE_W   = DATA_W / 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BE_W-1:0]   wr_be,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q
);

   for (genvar i = 0; i < BE_W; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[8*i +: 8] <= '0;
         else if (wr_en && wr_be[i])
            q[8*i +: 8] <= wr_data[8*i +: 8];
      end

      // R1
      areg_lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_be[i]) |=> (q[8*i +: 8] == $past(wr_data[8*i +: 8])));

      // R1
      areg_lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_be[i]) |=> $stable(q[8*i +: 8]));
   end

endmodule

// File: rtl/pcicfg_seq.sv
module pcicfg_seq
   import pcicfg_port_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DN_AW  = 32,
   parameter int CFG_AW = 24,
   parameter int IO_AW  = 16,
   parameter int BE_W   = DATA_W / 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  target_e           tgt,
   input  logic [BE_W-1:0]   be,
   input  logic [DATA_W-1:0] lane_mask,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] areg_q,
   output logic              areg_wr,
   output logic              host_ready,
   output logic [DATA_W-1:0] host_rdata,
   output logic              dn_req,
   output logic              dn_cfg,
   output logic              dn_we,
   output logic [DN_AW-1:0]  dn_addr,
   output logic [BE_W-1:0]   dn_be,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_ack,
   input  logic [DATA_W-1:0] dn_rdata
);

   seq_state_e         st_q;
   logic               win_hit;
   logic               launch;
   logic [DN_AW-1:0]   cyc_addr;
   logic [DATA_W-1:0]  mask_q;
   logic [DATA_W-1:0]  rdata_q;

   assign win_hit = host_req && ((tgt == TGT_CFG) || (tgt == TGT_IO));
   assign launch  = (st_q == ST_IDLE) && win_hit;
   assign areg_wr = (st_q == ST_IDLE) && host_req && host_we && (tgt == TGT_ADDR);

   // dword address for the cycle; lane choice travels in the enables
   always_comb begin
      cyc_addr = '0;
      if (tgt == TGT_CFG)
         cyc_addr[CFG_AW-1:2] = areg_q[CFG_AW-1:2];
      else
         cyc_addr[IO_AW-1:2] = areg_q[IO_AW-1:2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         dn_cfg   <= 1'b0;
         dn_we    <= 1'b0;
         dn_addr  <= '0;
         dn_be    <= '0;
         dn_wdata <= '0;
         mask_q   <= '0;
         rdata_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (launch) begin
                  st_q     <= ST_WAIT;
                  dn_cfg   <= (tgt == TGT_CFG);
                  dn_we    <= host_we;
                  dn_addr  <= cyc_addr;
                  dn_be    <= be;
                  dn_wdata <= host_wdata;
                  mask_q   <= lane_mask;
               end
            end
            ST_WAIT: begin
               if (dn_ack) begin
                  st_q    <= ST_DONE;
                  rdata_q <= dn_we ? '0 : (dn_rdata & mask_q);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign dn_req = (st_q == ST_WAIT);

   always_comb begin
      host_ready = 1'b0;
      host_rdata = '0;
      if (st_q == ST_DONE) begin
         host_ready = 1'b1;
         host_rdata = rdata_q;
      end else if ((st_q == ST_IDLE) && host_req && !win_hit) begin
         host_ready = 1'b1;
         if (!host_we && (tgt == TGT_ADDR))
            host_rdata = areg_q & lane_mask;
      end
   end

   // R6
   dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_be)));

   // R9
   ack_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && dn_ack) |=> (host_ready && !dn_req));

   // R5
   be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> (($countones(dn_be) == 1) || (dn_be == 4'b0011) ||
                  (dn_be == 4'b1100) || (dn_be == 4'b1111)));

   // R8
   no_dn_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |=> !dn_req);

   // R6
   ready_not_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> !host_ready);

endmodule

// File: rtl/pcicfg_port.sv
module pcicfg_port
   import pcicfg_port_pkg::*;
#(
   parameter int          HOST_AW  = 12,
   parameter int          DATA_W   = 32,
   parameter int          DN_AW    = 32,
   parameter int          CFG_AW   = 24,
   parameter int          IO_AW    = 16,
   parameter logic [11:0] ADDR_OFS = 12'h064,
   parameter logic [11:0] CFG_OFS  = 12'h068,
   parameter logic [11:0] IO_OFS   = 12'h06C
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [1:0]         host_size,
   input  logic [31:0]        host_wdata,
   output logic               host_ready,
   output logic [31:0]        host_rdata,
   output logic               dn_req,
   output logic               dn_cfg,
   output logic               dn_we,
   output logic [DN_AW-1:0]   dn_addr,
   output logic [3:0]         dn_be,
   output logic [31:0]        dn_wdata,
   input  logic               dn_ack,
   input  logic [31:0]        dn_rdata
);

   localparam int BE_W = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_width
      $error("pcicfg_port: DATA_W must be 32");
   end
   if ((CFG_AW > DN_AW) || (IO_AW > DN_AW) || (CFG_AW > DATA_W) || (IO_AW > DATA_W)
       || (CFG_AW < 3) || (IO_AW < 3)) begin : g_bad_aw
      $error("pcicfg_port: address widths out of range");
   end
   if ((ADDR_OFS[1:0] != 0) || (CFG_OFS[1:0] != 0) || (IO_OFS[1:0] != 0)) begin : g_bad_align
      $error("pcicfg_port: register offsets must be word aligned");
   end
   if ((ADDR_OFS == CFG_OFS) || (ADDR_OFS == IO_OFS) || (CFG_OFS == IO_OFS)) begin : g_bad_map
      $error("pcicfg_port: register offsets must differ");
   end

   target_e           tgt;
   logic [BE_W-1:0]   be;
   logic [DATA_W-1:0] lane_mask;
   logic [DATA_W-1:0] areg_q;
   logic              areg_wr;

   pcicfg_decode #(
      .HOST_AW (HOST_AW), .DATA_W (DATA_W),
      .ADDR_OFS(ADDR_OFS), .CFG_OFS(CFG_OFS), .IO_OFS(IO_OFS)
   ) u_decode (
      .host_addr(host_addr), .host_size(host_size),
      .tgt(tgt), .be(be), .lane_mask(lane_mask)
   );

   pcicfg_addr_reg #(.DATA_W(DATA_W)) u_areg (
      .clk(clk), .rst_n(rst_n), .wr_en(areg_wr), .wr_be(be),
      .wr_data(host_wdata), .q(areg_q)
   );

   pcicfg_seq #(
      .DATA_W(DATA_W), .DN_AW(DN_AW), .CFG_AW(CFG_AW), .IO_AW(IO_AW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .tgt(tgt), .be(be), .lane_mask(lane_mask), .host_wdata(host_wdata),
      .areg_q(areg_q), .areg_wr(areg_wr), .host_ready(host_ready),
      .host_rdata(host_rdata), .dn_req(dn_req), .dn_cfg(dn_cfg), .dn_we(dn_we),
      .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata),
      .dn_ack(dn_ack), .dn_rdata(dn_rdata)
   );

   // R7
   rdata_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && host_ready) |-> ((host_rdata & ~lane_mask) == '0));

   // R8
   stray_no_areg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && (tgt == TGT_NONE)) |=> $stable(areg_q));

endmodule

// File: tb/pcicfg_port_bench.sv
`timescale 1ns/1ps
module pcicfg_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [11:0] host_addr = '0;
   logic [1:0]  host_size = '0;
   logic [31:0] host_wdata = '0;
   logic        host_ready;
   logic [31:0] host_rdata;
   logic        dn_req, dn_cfg, dn_we;
   logic [31:0] dn_addr;
   logic [3:0]  dn_be;
   logic [31:0] dn_wdata;
   logic        dn_ack = 1'b0;
   logic [31:0] dn_rdata = '0;

   always #2 clk = ~clk;

   pcicfg_port u_pcicfg_port (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
      .host_ready(host_ready), .host_rdata(host_rdata), .dn_req(dn_req),
      .dn_cfg(dn_cfg), .dn_we(dn_we), .dn_addr(dn_addr), .dn_be(dn_be),
      .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] be_of(logic [1:0] sz, logic [1:0] ofs);
      if (sz == 2'd0) return 4'b0001 << ofs;
      if (sz == 2'd1) return ofs[1] ? 4'b1100 : 4'b0011;
      return 4'b1111;
   endfunction

   function automatic logic [31:0] mask_of(logic [3:0] b);
      return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
   endfunction

   // reference state
   logic [31:0] ref_areg = '0;
   logic [31:0] ref_mem [bit [32:0]];
   // responder device memory
   logic [31:0] dev_mem [bit [32:0]];

   // expectations for the downstream cycle of the current access
   bit          win_busy = 0;
   int          nacks = 0;
   int          lat = 0;
   int          wcnt = 0;
   bit          exp_cfg, exp_we;
   logic [31:0] exp_addr, exp_wd;
   logic [3:0]  exp_be;

   // behavioural responder and per-clock idle check
   always @(negedge clk) begin
      if (rst_n && !win_busy && dn_req)
         chk(0, "R9 dn_req outside window access", {31'd0, dn_req}, 32'd0);
      if (dn_ack) begin
         dn_ack = 1'b0;
         wcnt = 0;
      end else if (dn_req) begin
         if (wcnt >= lat) begin
            bit [32:0]   key;
            logic [31:0] m, old;
            key = {dn_cfg, dn_addr};
            m = mask_of(dn_be);
            chk(dn_cfg == exp_cfg, exp_cfg ? "R2 cycle type" : "R4 cycle type",
                {31'd0, dn_cfg}, {31'd0, exp_cfg});
            chk(dn_addr == exp_addr, exp_cfg ? "R2 address" : "R4 address", dn_addr, exp_addr);
            chk(dn_we == exp_we, exp_cfg ? "R3 direction" : "R4 direction",
                {31'd0, dn_we}, {31'd0, exp_we});
            chk(dn_be == exp_be, "R5 byte enables", {28'd0, dn_be}, {28'd0, exp_be});
            if (exp_we)
               chk((dn_wdata & m) == (exp_wd & m), "R3 write data", dn_wdata & m, exp_wd & m);
            old = dev_mem.exists(key) ? dev_mem[key] : 32'd0;
            if (dn_we) dev_mem[key] = (old & ~m) | (dn_wdata & m);
            dn_rdata = dn_we ? 32'hFFFF_FFFF : old;
            dn_ack = 1'b1;
            nacks++;
         end else begin
            wcnt++;
         end
      end
   end

   task automatic acc(bit we, logic [1:0] sz, logic [11:0] ofs, logic [31:0] wd,
                      string tag, output logic [31:0] rd);
      logic [3:0]  b;
      logic [31:0] m, exp_rd, old;
      bit          win;
      int          kind;
      bit [32:0]   key;
      b = be_of(sz, ofs[1:0]);
      m = mask_of(b);
      case (ofs[11:2])
         10'h019: kind = 1;
         10'h01A: kind = 2;
         10'h01B: kind = 3;
         default: kind = 0;
      endcase
      win = (kind >= 2);
      exp_cfg  = (kind == 2);
      exp_we   = we;
      exp_be   = b;
      exp_wd   = wd;
      exp_addr = (kind == 2) ? {8'h00, ref_areg[23:2], 2'b00} : {16'h0000, ref_areg[15:2], 2'b00};
      key = {exp_cfg, exp_addr};
      nacks = 0;
      win_busy = win;
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_size = sz; host_addr = ofs; host_wdata = wd;
      #1;
      while (!host_ready) begin
         @(negedge clk);
         #1;
      end
      rd = host_rdata;
      chk(nacks == (win ? 1 : 0), win ? "R6 ready only after one ack" : "R8 no downstream cycle",
          nacks, win ? 1 : 0);
      @(posedge clk);
      #1;
      host_req = 1'b0;
      win_busy = 0;
      old = ref_mem.exists(key) ? ref_mem[key] : 32'd0;
      exp_rd = 32'd0;
      if (we) begin
         if (kind == 1) ref_areg = (ref_areg & ~m) | (wd & m);
         if (win) ref_mem[key] = (old & ~m) | (wd & m);
      end else begin
         if (kind == 1) exp_rd = ref_areg & m;
         if (win) exp_rd = old & m;
      end
      chk(rd == exp_rd, tag, rd, exp_rd);
   endtask

   initial begin
      #(4 * 150000);
      chk(0, "watchdog expired", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      chk(host_ready == 1'b0 && dn_req == 1'b0, "R1 reset outputs idle",
          {30'd0, host_ready, dn_req}, 32'd0);
      rst_n = 1'b1;
      // R1 reset value and readback
      acc(0, 2'd2, 12'h064, 0, "R1 address register reset", rd);
      acc(1, 2'd2, 12'h064, 32'h0012_3457, "R1 write", rd);
      acc(0, 2'd2, 12'h064, 0, "R1 readback", rd);
      // R2 R3 word config write and read
      lat = 0;
      acc(1, 2'd2, 12'h068, 32'hDEAD_BEEF, "R3 config word write", rd);
      acc(0, 2'd2, 12'h068, 0, "R2 config word read", rd);
      // R5 R7 byte lanes
      for (int i = 0; i < 4; i++) begin
         lat = i;
         acc(1, 2'd0, 12'h068 + 12'(i), 32'h1122_3344 + 32'(i) * 32'h0101_0101, "R5 byte write", rd);
         acc(0, 2'd0, 12'h068 + 12'(i), 0, "R7 byte read lane", rd);
      end
      acc(0, 2'd2, 12'h068, 0, "R7 word after byte writes", rd);
      // halfwords, including odd offsets
      lat = 2;
      acc(1, 2'd1, 12'h06A, 32'hCAFE_0000, "R5 upper half write", rd);
      acc(0, 2'd1, 12'h068, 0, "R7 lower half read", rd);
      acc(0, 2'd1, 12'h06B, 0, "R5 half at odd offset", rd);
      acc(0, 2'd3, 12'h068, 0, "R5 size 3 as word", rd);
      // another configuration address keeps separate storage
      acc(1, 2'd2, 12'h064, 32'hFF01_0A08, "R1 second address", rd);
      lat = 1;
      acc(0, 2'd2, 12'h068, 0, "R2 new address reads zero", rd);
      acc(1, 2'd0, 12'h069, 32'h0000_7700, "R3 byte at new address", rd);
      acc(0, 2'd2, 12'h068, 0, "R7 word at new address", rd);
      // I/O port cycles
      acc(1, 2'd2, 12'h064, 32'h0000_03F9, "R1 port number", rd);
      acc(1, 2'd0, 12'h06D, 32'h0000_5A00, "R4 I/O byte write", rd);
      acc(0, 2'd0, 12'h06D, 0, "R4 I/O byte read", rd);
      lat = 3;
      acc(1, 2'd2, 12'h06C, 32'h8765_4321, "R4 I/O word write", rd);
      acc(0, 2'd1, 12'h06E, 0, "R4 I/O half read", rd);
      // unmapped offsets
      acc(1, 2'd2, 12'h070, 32'hFFFF_FFFF, "R8 stray write", rd);
      acc(0, 2'd2, 12'h070, 0, "R8 stray read", rd);
      acc(1, 2'd2, 12'h060, 32'h1234_5678, "R8 stray write below", rd);
      acc(0, 2'd2, 12'h064, 0, "R8 address register untouched", rd);
      // partial address register write
      acc(1, 2'd1, 12'h066, 32'h00AB_0000, "R1 half write", rd);
      acc(0, 2'd2, 12'h064, 0, "R1 half write merged", rd);
      acc(0, 2'd0, 12'h066, 0, "R1 byte readback", rd);
      repeat (4) @(negedge clk);
      chk(dn_req == 1'b0, "R9 idle at end", {31'd0, dn_req}, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule